// File: doc/BRIEF.md
# Outbound Request Segmenter

This block sits between an application that issues bulk transfer commands and a packet-building transaction layer. Each command names a byte start address, a byte length, a direction (read or write) and an application command ID. The block cuts the command into request pieces, each of which obeys the packet rules. A piece never crosses a 4 KB page boundary. A read piece never asks for more than the configured maximum read request size. A write piece never carries more than the configured maximum payload. For each piece the block emits a descriptor: a dword-aligned address, a length in dwords, first and last dword byte enables, and a tag.

Read pieces draw a tag from a pool of 32. A completion status report returns the tag to the pool. Completions may arrive in any order. A report of Unsupported Request or Completer Abort also raises a one-cycle error indication that carries the ID of the command that owned the tag. When the pool is empty, read pieces wait. The block does not handle the data path, packet framing, CRC or link retry.

Top module: `xfer_splitter`

## Requirements
- R1: The pieces of one command are emitted in ascending address order. Together they cover exactly the command's bytes with no gap or overlap. `pc_addr` is the command byte address with bits [1:0] cleared, and `pc_dwords` is never zero.
- R2: The dwords spanned by a read piece hold at most 128 << n bytes, where n is `cfg_max_read`. Codes 6 and 7 act as code 5 (4096 bytes). When the start is unaligned, the piece's byte count drops by the start offset so that this span limit is kept.
- R3: The dwords spanned by a write piece hold at most 128 << n bytes, where n is `cfg_max_payload`. Codes 6 and 7 act as 5.
- R4: No piece spans a 4 KB address boundary. Each piece is as long as the smallest of three bounds: the bytes remaining, the size bound, and the bytes left in the current page.
- R5: Bit i of `pc_first_be` enables byte i of the first dword. In a piece of two or more dwords, `pc_last_be` enables the bytes of the last dword up to the last byte. In a single-dword piece, `pc_first_be` covers just the piece's bytes and `pc_last_be` is 4'b0000.
- R6: Each read piece carries the lowest-numbered free tag of the 32-entry pool and marks that tag in use. Write pieces carry tag 0 and consume no tag.
- R7: While every tag is in use, a pending read piece holds `pc_valid` low. It is offered as soon as a tag is freed.
- R8: A `cpl_valid` pulse for an in-use tag frees that tag, whatever its status. Status codes: 0 = success, 1 = Unsupported Request, 2 = Completer Abort, 3 = reserved.
- R9: A completion for an in-use tag with a non-zero status raises `err_valid` for one cycle, in the cycle after the report. `err_id` then holds the command ID that owned the tag and `err_status` holds the status. A completion for a tag that is not in use has no effect.
- R10: While `pc_valid` is high and `pc_ready` is low, `pc_valid`, `pc_addr` and `pc_dwords` hold. A piece is consumed on a cycle where both are high.
- R11: After reset `cmd_ready` is 1 and `pc_valid` and `err_valid` are 0. `cmd_ready` stays low from the accepting edge until the edge that consumes the command's last piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_max_read | input | 3 | Read request size code, 128 << n bytes |
| cfg_max_payload | input | 3 | Write payload size code, 128 << n bytes |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Segmenter idle and taking a command |
| cmd_addr | input | 32 | Command start byte address |
| cmd_len | input | 16 | Command length in bytes (non-zero) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_id | input | 8 | Application command ID |
| pc_valid | output | 1 | Piece descriptor valid |
| pc_ready | input | 1 | Downstream takes the piece |
| pc_addr | output | 32 | Dword-aligned piece address |
| pc_dwords | output | 11 | Piece length in dwords |
| pc_first_be | output | 4 | First dword byte enables |
| pc_last_be | output | 4 | Last dword byte enables |
| pc_tag | output | 5 | Tag of a read piece, 0 for writes |
| pc_write | output | 1 | Piece direction |
| pc_id | output | 8 | Command ID of the piece |
| cpl_valid | input | 1 | Completion status report |
| cpl_tag | input | 5 | Tag being completed |
| cpl_status | input | 2 | Completion status code |
| err_valid | output | 1 | Error report pulse |
| err_id | output | 8 | Command ID of the failed read |
| err_status | output | 2 | Failing status code |

## Verification
The assertions rely on four properties of the inputs. Both size codes hold steady while a command is in progress. `cmd_len` is never zero. At most one completion arrives per cycle. Only the downstream side retires tags, through `cpl_tag`. The bench changes the size codes only between commands, while `cmd_ready` is high. Every command it issues has a non-zero length. It drives `cpl_valid` for single cycles and, in its own model, frees only the tags it has seen issued. The one exception is a deliberate report on a free tag, used to show that such a report has no effect.

// File: rtl/seg_pkg.sv
// Shared constants and helpers for the outbound request segmenter.
// Assumes a 4 KB page and size codes of the form 128 << n bytes.
package seg_pkg;
    localparam int PAGE_LOG   = 12;
    localparam int PAGE_BYTES = 1 << PAGE_LOG;
    localparam int ROOM_W     = PAGE_LOG + 1;     // holds 0..PAGE_BYTES
    localparam int DW_W       = PAGE_LOG - 1;     // holds 0..PAGE_BYTES/4
    localparam int MAX_CODE   = 5;

    localparam logic [1:0] CPL_OK  = 2'd0;
    localparam logic [1:0] CPL_UR  = 2'd1;
    localparam logic [1:0] CPL_CA  = 2'd2;
    localparam logic [1:0] CPL_RSV = 2'd3;

    // Byte bound for a size code; codes above MAX_CODE saturate.
    function automatic logic [ROOM_W-1:0] size_bytes(input logic [2:0] code);
        logic [2:0] c;
        c = (int'(code) > MAX_CODE) ? 3'(MAX_CODE) : code;
        return ROOM_W'(128) << c;
    endfunction
endpackage

// File: rtl/seg_piece_calc.sv
// Combinational sizing of the next piece from the current cursor.
// Picks the smallest of: bytes remaining, size bound less start offset,
// bytes left in the page. Derives dword count and byte enables.
// Assumes rem is non-zero and LEN_W >= ROOM_W.
module seg_piece_calc
    import seg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  rem,
    input  logic [2:0]        limit_code,
    output logic [LEN_W-1:0]  plen,
    output logic [DW_W-1:0]   dwords,
    output logic [3:0]        first_be,
    output logic [3:0]        last_be,
    output logic              is_last
);
    localparam int SPAN_W = DW_W + 2;

    logic [1:0]        off;
    logic [ROOM_W-1:0] lim_room;
    logic [ROOM_W-1:0] page_room;
    logic [ROOM_W-1:0] cap;
    logic [SPAN_W-1:0] span;
    logic [1:0]        end_off;
    logic [3:0]        head_mask;
    logic [3:0]        tail_mask;

    // Size the piece against the three bounds.
    always_comb begin
        off       = cur_addr[1:0];
        lim_room  = size_bytes(limit_code) - ROOM_W'(off);
        page_room = ROOM_W'(PAGE_BYTES) - ROOM_W'(cur_addr[PAGE_LOG-1:0]);
        cap       = (lim_room < page_room) ? lim_room : page_room;
        plen      = (rem < LEN_W'(cap)) ? rem : LEN_W'(cap);
        is_last   = (plen == rem);
    end

    // Dword span and byte enables of the sized piece.
    always_comb begin
        span      = SPAN_W'(plen) + SPAN_W'(off) + SPAN_W'(3);
        dwords    = span[SPAN_W-1:2];
        end_off   = span[1:0];
        head_mask = 4'b1111 << off;
        tail_mask = 4'b1111 >> (2'd3 - end_off);
        if (dwords == DW_W'(1)) begin
            first_be = head_mask & tail_mask;
            last_be  = 4'b0000;
        end else begin
            first_be = head_mask;
            last_be  = tail_mask;
        end
    end
endmodule

// File: rtl/seg_tag_pool.sv
// Read tag pool: hands out the lowest free tag, records the owning command
// ID, frees tags on completion and reports failing completions one cycle
// later. Assumes at most one allocation and one completion per cycle.
module seg_tag_pool
    import seg_pkg::*;
#(
    parameter int TAGS = 32,
    parameter int ID_W = 8,
    localparam int TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [ID_W-1:0]  alloc_id,
    output logic [TAG_W-1:0] free_tag,
    output logic             any_free,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [1:0]       cpl_status,
    output logic             err_valid,
    output logic [ID_W-1:0]  err_id,
    output logic [1:0]       err_status
);
    logic [TAGS-1:0] busy_q;
    logic [ID_W-1:0] owner_q [TAGS];
    logic [TAGS-1:0] take_hit;
    logic [TAGS-1:0] drop_hit;
    logic            cpl_live;

    // Per-slot decode of allocation and release.
    for (genvar g = 0; g < TAGS; g++) begin : g_slot
        assign take_hit[g] = alloc && (free_tag == TAG_W'(g));
        assign drop_hit[g] = cpl_valid && (cpl_tag == TAG_W'(g));
    end

    // Lowest-index free tag.
    always_comb begin
        free_tag = '0;
        any_free = 1'b0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                free_tag = TAG_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign cpl_live = cpl_valid && busy_q[cpl_tag];

    // Slot state: allocation wins over a release of the same slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int i = 0; i < TAGS; i++) owner_q[i] <= '0;
        end else begin
            for (int i = 0; i < TAGS; i++) begin
                if (take_hit[i]) begin
                    busy_q[i]  <= 1'b1;
                    owner_q[i] <= alloc_id;
                end else if (drop_hit[i]) begin
                    busy_q[i] <= 1'b0;
                end
            end
        end
    end

    // Error report for failing completions of live tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid  <= 1'b0;
            err_id     <= '0;
            err_status <= CPL_OK;
        end else begin
            err_valid <= cpl_live && (cpl_status != CPL_OK);
            if (cpl_live) begin
                err_id     <= owner_q[cpl_tag];
                err_status <= cpl_status;
            end
        end
    end

    AST_ALLOC_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> any_free); // R7
    AST_ERR_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(cpl_live)); // R9
    AST_CPL_FREES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !alloc) |=> !busy_q[$past(cpl_tag)]); // R8
endmodule

// File: rtl/xfer_splitter.sv
// Outbound request segmenter top. Holds a cursor over the current command,
// emits one piece per accepted handshake and takes a new command only when
// idle. Read pieces stall while the tag pool is empty.
// Assumes the size codes are steady while a command is in progress and
// cmd_len is non-zero.
module xfer_splitter
    import seg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int ID_W   = 8,
    parameter int TAGS   = 32,
    localparam int TAG_W = $clog2(TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_max_read,
    input  logic [2:0]        cfg_max_payload,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_write,
    input  logic [ID_W-1:0]   cmd_id,
    output logic              pc_valid,
    input  logic              pc_ready,
    output logic [ADDR_W-1:0] pc_addr,
    output logic [DW_W-1:0]   pc_dwords,
    output logic [3:0]        pc_first_be,
    output logic [3:0]        pc_last_be,
    output logic [TAG_W-1:0]  pc_tag,
    output logic              pc_write,
    output logic [ID_W-1:0]   pc_id,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [1:0]        cpl_status,
    output logic              err_valid,
    output logic [ID_W-1:0]   err_id,
    output logic [1:0]        err_status
);
    logic              active_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              wr_q;
    logic [ID_W-1:0]   id_q;

    logic [2:0]        limit_code;
    logic [LEN_W-1:0]  plen;
    logic              is_last;
    logic [TAG_W-1:0]  free_tag;
    logic              any_free;
    logic              fire;
    logic              alloc;

    assign limit_code = wr_q ? cfg_max_payload : cfg_max_read;

    seg_piece_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_calc (
        .cur_addr   (addr_q),
        .rem        (rem_q),
        .limit_code (limit_code),
        .plen       (plen),
        .dwords     (pc_dwords),
        .first_be   (pc_first_be),
        .last_be    (pc_last_be),
        .is_last    (is_last)
    );

    seg_tag_pool #(.TAGS(TAGS), .ID_W(ID_W)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc),
        .alloc_id   (id_q),
        .free_tag   (free_tag),
        .any_free   (any_free),
        .cpl_valid  (cpl_valid),
        .cpl_tag    (cpl_tag),
        .cpl_status (cpl_status),
        .err_valid  (err_valid),
        .err_id     (err_id),
        .err_status (err_status)
    );

    // Handshake and descriptor outputs.
    always_comb begin
        cmd_ready = !active_q;
        pc_valid  = active_q && (wr_q || any_free);
        fire      = pc_valid && pc_ready;
        alloc     = fire && !wr_q;
        pc_addr   = {addr_q[ADDR_W-1:2], 2'b00};
        pc_tag    = wr_q ? '0 : free_tag;
        pc_write  = wr_q;
        pc_id     = id_q;
    end

    // Command cursor: load when idle, advance on each consumed piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            rem_q    <= '0;
            wr_q     <= 1'b0;
            id_q     <= '0;
        end else if (!active_q) begin
            if (cmd_valid) begin
                active_q <= 1'b1;
                addr_q   <= cmd_addr;
                rem_q    <= cmd_len;
                wr_q     <= cmd_write;
                id_q     <= cmd_id;
            end
        end else if (fire) begin
            addr_q <= addr_q + ADDR_W'(plen);
            rem_q  <= rem_q - plen;
            if (is_last) active_q <= 1'b0;
        end
    end

    AST_NONZERO_PIECE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> (pc_dwords != '0)); // R1
    AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && !pc_write) |->
        ((ROOM_W + 1)'({pc_dwords, 2'b00}) <= (ROOM_W + 1)'(size_bytes(cfg_max_read)))); // R2
    AST_WRITE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && pc_write) |->
        ((ROOM_W + 1)'({pc_dwords, 2'b00}) <= (ROOM_W + 1)'(size_bytes(cfg_max_payload)))); // R3
    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> (((ROOM_W + 1)'(pc_addr[PAGE_LOG-1:0]) + (ROOM_W + 1)'({pc_dwords, 2'b00}))
                      <= (ROOM_W + 1)'(PAGE_BYTES))); // R4
    AST_SINGLE_DW_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && pc_dwords == DW_W'(1)) |-> (pc_last_be == 4'b0000 && pc_first_be != 4'b0000)); // R5
    AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && !pc_ready) |=> (pc_valid && $stable(pc_addr) && $stable(pc_dwords))); // R10
    AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> !cmd_ready); // R11
endmodule

// File: tb/tb_xfer_splitter.sv
module tb_xfer_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_max_read = 3'd0;
    logic [2:0]  cfg_max_payload = 3'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_id = '0;
    logic        pc_valid;
    logic        pc_ready = 1'b1;
    logic [31:0] pc_addr;
    logic [10:0] pc_dwords;
    logic [3:0]  pc_first_be;
    logic [3:0]  pc_last_be;
    logic [4:0]  pc_tag;
    logic        pc_write;
    logic [7:0]  pc_id;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_tag = '0;
    logic [1:0]  cpl_status = '0;
    logic        err_valid;
    logic [7:0]  err_id;
    logic [1:0]  err_status;

    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    logic [31:0] mbusy = '0;

    always #5 clk = ~clk;

    xfer_splitter dut (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected piece from the rules: min(remaining, bound - offset, page room).
    task automatic model_piece(input int a, input int r, input int code,
                               output int plen, output int dw, output int fbe, output int lbe);
        int lim, room, off, e;
        lim  = 128 << ((code > 5) ? 5 : code);
        off  = a % 4;
        room = 4096 - (a % 4096);
        plen = r;
        if (lim - off < plen) plen = lim - off;
        if (room < plen) plen = room;
        dw   = (off + plen + 3) / 4;
        e    = (off + plen - 1) % 4;
        fbe  = (4'b1111 << off) & 4'hF;
        lbe  = 4'b1111 >> (3 - e);
        if (dw == 1) begin
            fbe = fbe & lbe;
            lbe = 0;
        end
    endtask

    function automatic int low_free();
        for (int t = 0; t < 32; t++) if (!mbusy[t]) return t;
        return -1;
    endfunction

    // Issue one command and check every piece with pc_ready held high.
    task automatic run_cmd(input int a, input int len, input bit wr, input int id);
        int r, plen, dw, fbe, lbe, tg;
        @(negedge clk);
        chk("R11", "cmd_ready idle", cmd_ready, 1);
        cmd_addr = a; cmd_len = len; cmd_write = wr; cmd_id = id; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        r = len;
        while (r > 0) begin
            model_piece(a, r, wr ? cfg_max_payload : cfg_max_read, plen, dw, fbe, lbe);
            chk("R11", "cmd_ready busy", cmd_ready, 0);
            chk("R1", "pc_valid", pc_valid, 1);
            chk("R1", "pc_addr", pc_addr, a & ~3);
            chk(wr ? "R3" : "R2", "pc_dwords limit", pc_dwords, dw);
            chk("R4", "page split dwords", pc_dwords, dw);
            chk("R5", "first_be", pc_first_be, fbe);
            chk("R5", "last_be", pc_last_be, lbe);
            chk("R1", "pc_write", pc_write, wr);
            chk("R1", "pc_id", pc_id, id);
            tg = wr ? 0 : low_free();
            chk("R6", "pc_tag", pc_tag, tg);
            if (!wr) mbusy[tg] = 1'b1;
            a = a + plen; r = r - plen;
            @(negedge clk);
        end
        chk("R11", "cmd_ready after last", cmd_ready, 1);
        chk("R1", "no extra piece", pc_valid, 0);
    endtask

    // Send one completion and check the error report one cycle later.
    task automatic complete(input int tag, input int st, input bit exp_err, input int exp_id);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = tag; cpl_status = st;
        @(negedge clk);
        cpl_valid = 1'b0;
        chk("R9", "err_valid", err_valid, exp_err);
        if (exp_err) begin
            chk("R9", "err_id", err_id, exp_id);
            chk("R9", "err_status", err_status, st);
        end
        mbusy[tag] = 1'b0;
    endtask

    task automatic drain_tags();
        for (int t = 0; t < 32; t++) if (mbusy[t]) complete(t, 0, 1'b0, 0);
    endtask

    task automatic t_reset();
        chk("R11", "reset cmd_ready", cmd_ready, 1);
        chk("R11", "reset pc_valid", pc_valid, 0);
        chk("R11", "reset err_valid", err_valid, 0);
    endtask

    task automatic t_aligned_write();
        cfg_max_payload = 3'd0;
        run_cmd(32'h0000_1000, 512, 1'b1, 8'h11);   // R3: four 128-byte pieces
    endtask

    task automatic t_page_cross();
        cfg_max_read = 3'd2;
        run_cmd(32'h0000_0FC0, 256, 1'b0, 8'h22);   // R4: 64 then 192 bytes
        drain_tags();
    endtask

    task automatic t_unaligned();
        cfg_max_read = 3'd0;
        run_cmd(32'h0000_0003, 300, 1'b0, 8'h23);   // R2: 125, 128, 47 bytes
        run_cmd(32'h0000_1001, 6, 1'b0, 8'h24);     // R5: two dwords
        cfg_max_payload = 3'd1;
        run_cmd(32'h0000_2001, 2, 1'b1, 8'h25);     // R5: single dword
        drain_tags();
    endtask

    task automatic t_clamp();
        cfg_max_payload = 3'd7;                      // R3: saturates at 4096
        run_cmd(32'h0000_0010, 8192, 1'b1, 8'h26);
    endtask

    task automatic t_tag_stall();
        cfg_max_read = 3'd0;
        run_cmd(32'h0, 4096, 1'b0, 8'h31);          // R6: tags 0..31
        @(negedge clk);
        pc_ready = 1'b0;
        cmd_addr = 32'h8000; cmd_len = 64; cmd_write = 1'b0; cmd_id = 8'h32; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R7", "stall with empty pool", pc_valid, 0);
            @(negedge clk);
        end
        complete(7, 0, 1'b0, 0);
        chk("R7", "valid after free", pc_valid, 1);
        chk("R8", "freed tag reissued", pc_tag, 7);
        complete(3, 0, 1'b0, 0);
        chk("R6", "lowest free tag", pc_tag, 3);
        chk("R1", "stalled piece addr", pc_addr, 32'h8000);
        chk("R1", "stalled piece dwords", pc_dwords, 16);
        pc_ready = 1'b1;
        mbusy[3] = 1'b1;
        @(negedge clk);
        chk("R11", "ready after stalled piece", cmd_ready, 1);
        drain_tags();
    endtask

    task automatic t_errors();
        cfg_max_read = 3'd1;
        run_cmd(32'h100, 16, 1'b0, 8'h5A);          // tag 0
        run_cmd(32'h200, 8, 1'b0, 8'h33);           // tag 1
        complete(1, 2, 1'b1, 8'h33);                // R9: abort
        complete(0, 1, 1'b1, 8'h5A);                // R9: unsupported
        complete(0, 1, 1'b0, 0);                    // R9: free tag ignored
        run_cmd(32'h300, 4, 1'b0, 8'h44);           // R8: tag 0 free again
        complete(0, 3, 1'b1, 8'h44);                // R8: reserved status frees
        run_cmd(32'h400, 4, 1'b0, 8'h45);
        drain_tags();
    endtask

    task automatic t_backpressure();
        cfg_max_payload = 3'd0;
        @(negedge clk);
        pc_ready = 1'b0;
        cmd_addr = 32'h40; cmd_len = 64; cmd_write = 1'b1; cmd_id = 8'h66; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10", "valid held", pc_valid, 1);
            chk("R10", "addr held", pc_addr, 32'h40);
            chk("R10", "dwords held", pc_dwords, 16);
            @(negedge clk);
        end
        pc_ready = 1'b1;
        @(negedge clk);
        chk("R10", "consumed after ready", pc_valid, 0);
        chk("R11", "idle after consume", cmd_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aligned_write();
        t_page_cross();
        t_unaligned();
        t_clamp();
        t_tag_stall();
        t_errors();
        t_backpressure();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule